// File: doc/BRIEF.md
# Synchronous Serial Byte Port with Transfer Status Flags

This block moves one byte at a time over a clocked serial line and reports what happened through a small status register. The serial clock arrives as a level on `sckIn`, sampled in the system clock domain. Data is shifted most significant bit first. The received bit is captured on each rising serial-clock edge, and the transmit bit advances on each falling edge. An auxiliary input pin is captured once per byte, on the eighth rising edge.

A host reads the status register and accesses the data register through single-cycle strobes. Three status bits are reported: a completion flag, a collision flag and the captured pin sample. Both flags are cleared by one two-step handshake. First, the host reads the status register while the completion flag is set. Then it reads or writes the data register. A data-register access made while a byte is mid-flight is a collision.

A master-start request produces a one-cycle start pulse for an external clock generator. The pulse is withheld while the completion flag is still set.

Top module: `spflag_unit`

## Requirements
- R1: After reset, `statusOut` reads 0x00, `rxData` reads 0x00 and `xferStart` is 0.
- R2: `statusOut` places the collision flag at bit 7, the completion flag at bit 6 and the captured pin sample at bit 0. Bits 5 down to 1 always read 0.
- R3: The completion flag reads 1 from the system-clock edge that first sees the eighth rising `sckIn` edge of a byte. It is still 0 after the seventh rising edge.
- R4: A status read with the completion flag at 1 arms the clear. The next data read or write then clears both flags. A data access without that prior armed read clears nothing. A status read taken while the completion flag is 0 does not arm.
- R5: If the clear finishes while the next byte is still in progress, the completion flag is set again when that byte's eighth rising edge arrives.
- R6: A data read or write made after the first falling `sckIn` edge of a byte, and before that byte completes, sets the collision flag. An access after the first rising edge but before the first falling edge does not set it. A write that collides does not load the shifter.
- R7: If the data access that finishes the clear falls inside the collision window of a new byte, the completion flag clears but the collision flag reads 1 again.
- R8: The pin sample at bit 0 is the `auxPin` level at the eighth rising edge, whatever `masterMode` and `clkPol` are set to. It holds between byte completions.
- R9: `sdo` presents bit 7 of the shifter and advances one bit on each falling edge within a byte. A non-colliding write loads the shifter. `rxData` is the last received byte, assembled MSB first from `sdi` sampled on rising edges.
- R10: `xferStart` pulses for one cycle, the cycle after `startReq`, only when all of these hold: `masterMode` is 1, the completion flag is 0, no byte is in progress, and `sckIn` equals `clkPol`. Otherwise it stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rdStatus | input | 1 | Status register read strobe |
| rdData | input | 1 | Data register read strobe |
| wrData | input | 1 | Data register write strobe |
| wrValue | input | DATA_W | Data written to the shifter |
| statusOut | output | 8 | Status register contents |
| rxData | output | DATA_W | Last received byte |
| sckIn | input | 1 | Serial clock line level |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| auxPin | input | 1 | Auxiliary pin captured at byte end |
| masterMode | input | 1 | Master role select |
| clkPol | input | 1 | Idle level of the serial clock |
| startReq | input | 1 | Master start request |
| xferStart | output | 1 | One-cycle master start pulse |

## Verification
The bench targets the collision window boundaries. A write placed between the first rising and first falling edge must load the shifter without a collision. A write after the first falling edge must be dropped, which shows in the transmitted bit stream. A design that opened the window one edge early, or let a colliding write through, would flag a collision or send the wrong bits.

It also runs the clear handshake in several broken orders. These are a data access without a status read, and a status read taken while the flag was clear. A design that armed on any status read would drop the flag too early.

Finishing the clear mid-byte must leave the collision flag set and bring the completion flag back at byte end. The start pulse is tried under each blocking condition, since a missing gate would emit a pulse where none belongs.

// File: rtl/spflag_pkg.sv
package spflag_pkg;
  // strobes from the flag/sequencing control to the datapath
  typedef struct packed {
    logic loadTx;    // host write accepted into the shifter
    logic capture;   // rising serial edge: sample sdi
    logic shift;     // falling serial edge inside a byte: advance shifter
    logic complete;  // eighth rising edge: capture byte and pin
  } spflag_strobe_t;
endpackage

// File: rtl/spflag_ctrl.sv
module spflag_ctrl
  import spflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sckIn,
  input  logic           rdStatus,
  input  logic           rdData,
  input  logic           wrData,
  input  logic           masterMode,
  input  logic           clkPol,
  input  logic           startReq,
  output logic           doneFlag,
  output logic           collFlag,
  output logic           xferStart,
  output spflag_strobe_t strb
);
  localparam int CNT_W = $clog2(DATA_W + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);

  logic             sckPrev;
  logic [CNT_W-1:0] riseCnt;
  logic             winOpen;
  logic             armed;

  logic sckRise, sckFall, lastRise, dataAcc, collSet, clearNow, startOk;

  always_comb begin
    sckRise  = sckIn & ~sckPrev;
    sckFall  = ~sckIn & sckPrev;
    lastRise = sckRise && (riseCnt == LAST_IDX);
    dataAcc  = rdData | wrData;
    collSet  = dataAcc && winOpen;
    clearNow = dataAcc && armed;
    startOk  = startReq && masterMode && !doneFlag && (riseCnt == '0)
               && !winOpen && (sckIn == clkPol);
    strb.loadTx   = wrData && !collSet;
    strb.capture  = sckRise;
    strb.shift    = sckFall && (riseCnt != '0);
    strb.complete = lastRise;
  end

  // edge tracking and bit counting
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sckPrev <= 1'b0;
      riseCnt <= '0;
      winOpen <= 1'b0;
    end else begin
      sckPrev <= sckIn;
      if (sckRise) riseCnt <= lastRise ? '0 : riseCnt + 1'b1;
      if (lastRise) winOpen <= 1'b0;
      else if (sckFall && (riseCnt != '0)) winOpen <= 1'b1;
    end
  end

  // flag state machines: set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      doneFlag  <= 1'b0;
      collFlag  <= 1'b0;
      armed     <= 1'b0;
      xferStart <= 1'b0;
    end else begin
      if (lastRise) doneFlag <= 1'b1;
      else if (clearNow) doneFlag <= 1'b0;

      if (collSet) collFlag <= 1'b1;
      else if (clearNow) collFlag <= 1'b0;

      if (dataAcc) armed <= 1'b0;
      else if (rdStatus && doneFlag) armed <= 1'b1;
      else if (!doneFlag) armed <= 1'b0;

      xferStart <= startOk;
    end
  end

  p_done_on_last_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(doneFlag) |-> $past(lastRise));
  p_done_clear_needs_arm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(doneFlag) |-> $past(armed && dataAcc));
  p_arm_implies_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> doneFlag);
  p_coll_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(collFlag) |-> $past(winOpen && dataAcc));
  p_start_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
    xferStart |-> $past(!doneFlag && masterMode && startReq));
endmodule

// File: rtl/spflag_dpath.sv
module spflag_dpath
  import spflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  spflag_strobe_t    strb,
  input  logic [DATA_W-1:0] wrValue,
  input  logic              sdi,
  input  logic              auxPin,
  output logic              sdo,
  output logic [DATA_W-1:0] rxData,
  output logic              pinLatch
);
  logic [DATA_W-1:0] shiftReg;
  logic              sampleBit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      sampleBit <= 1'b0;
      rxData    <= '0;
      pinLatch  <= 1'b0;
    end else begin
      if (strb.capture) sampleBit <= sdi;
      if (strb.loadTx) shiftReg <= wrValue;
      else if (strb.shift) shiftReg <= {shiftReg[DATA_W-2:0], sampleBit};
      if (strb.complete) begin
        rxData   <= {shiftReg[DATA_W-2:0], sdi};
        pinLatch <= auxPin;
      end
    end
  end

  assign sdo = shiftReg[DATA_W-1];

  p_pin_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.complete |=> $stable(pinLatch));
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !strb.complete |=> $stable(rxData));
endmodule

// File: rtl/spflag_unit.sv
module spflag_unit
  import spflag_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rdStatus,
  input  logic              rdData,
  input  logic              wrData,
  input  logic [DATA_W-1:0] wrValue,
  output logic [7:0]        statusOut,
  output logic [DATA_W-1:0] rxData,
  input  logic              sckIn,
  input  logic              sdi,
  output logic              sdo,
  input  logic              auxPin,
  input  logic              masterMode,
  input  logic              clkPol,
  input  logic              startReq,
  output logic              xferStart
);
  spflag_strobe_t strb;
  logic doneFlag, collFlag, pinLatch;

  spflag_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sckIn(sckIn), .rdStatus(rdStatus),
    .rdData(rdData), .wrData(wrData), .masterMode(masterMode),
    .clkPol(clkPol), .startReq(startReq), .doneFlag(doneFlag),
    .collFlag(collFlag), .xferStart(xferStart), .strb(strb)
  );

  spflag_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rst_n(rst_n), .strb(strb), .wrValue(wrValue), .sdi(sdi),
    .auxPin(auxPin), .sdo(sdo), .rxData(rxData), .pinLatch(pinLatch)
  );

  assign statusOut = {collFlag, doneFlag, 5'b00000, pinLatch};
endmodule

// File: tb/spflag_unit_bench.sv
module spflag_unit_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rdStatus = 0, rdData = 0, wrData = 0;
  logic [7:0] wrValue = 8'h00;
  logic [7:0] statusOut, rxData;
  logic sckIn = 0, sdi = 0, sdo, auxPin = 0;
  logic masterMode = 0, clkPol = 0, startReq = 0, xferStart;
  int nChecks = 0, nFails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spflag_unit u_spflag_unit (
    .clk(clk), .rst_n(rst_n), .rdStatus(rdStatus), .rdData(rdData),
    .wrData(wrData), .wrValue(wrValue), .statusOut(statusOut), .rxData(rxData),
    .sckIn(sckIn), .sdi(sdi), .sdo(sdo), .auxPin(auxPin),
    .masterMode(masterMode), .clkPol(clkPol), .startReq(startReq),
    .xferStart(xferStart)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nChecks++;
    if (got !== exp) begin
      nFails++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, got, exp);
    end
  endtask

  task automatic sckEdge(input logic lvl);
    @(negedge clk) sckIn = lvl;
    @(negedge clk);
  endtask

  task automatic readStatus(output logic [7:0] v);
    @(negedge clk) rdStatus = 1; v = statusOut;
    @(negedge clk) rdStatus = 0;
  endtask

  task automatic dataRead();
    @(negedge clk) rdData = 1;
    @(negedge clk) rdData = 0;
  endtask

  task automatic dataWrite(input logic [7:0] v);
    @(negedge clk) wrData = 1; wrValue = v;
    @(negedge clk) wrData = 0;
  endtask

  // one serial bit: present sdi, record sdo, rising then falling edge
  task automatic bitCycle(input logic b, output logic seen);
    @(negedge clk) sdi = b; seen = sdo;
    sckEdge(1);
    sckEdge(0);
  endtask

  task automatic runByte(input logic [7:0] rx, input logic pin, output logic [7:0] txSeen);
    for (int i = 7; i >= 0; i--) begin
      if (i == 0) auxPin = pin;
      bitCycle(rx[i], txSeen[i]);
    end
  endtask

  task automatic tryStart(input string tag, input logic exp);
    @(negedge clk) startReq = 1;
    @(negedge clk) startReq = 0; check(tag, {7'b0, xferStart}, {7'b0, exp});
    @(negedge clk) check({tag, " one-cycle"}, {7'b0, xferStart}, 8'h00);
  endtask

  task automatic fullClear();
    logic [7:0] s;
    readStatus(s);
    dataRead();
  endtask

  task automatic t_reset();
    check("R1 status", statusOut, 8'h00);
    check("R1 rxData", rxData, 8'h00);
    check("R1 xferStart", {7'b0, xferStart}, 8'h00);
  endtask

  task automatic t_basicByte();
    logic [7:0] tx;
    logic seen;
    dataWrite(8'hA5);
    for (int i = 7; i >= 1; i--) bitCycle(8'h3C >> i, tx[i]);
    check("R3 done clear after 7th rise", statusOut, 8'h00);
    @(negedge clk) sdi = 1'b0; auxPin = 1; tx[0] = sdo;
    sckEdge(1);
    check("R3 R2 done and pin after 8th rise", statusOut, 8'h41);
    check("R9 rx byte", rxData, 8'h3C);
    check("R9 tx MSB first", tx, 8'hA5);
    sckEdge(0);
    seen = sdo;
  endtask

  task automatic t_clearSeq();
    logic [7:0] s, tx;
    dataRead();
    check("R4 no clear without status read", statusOut, 8'h41);
    readStatus(s);
    check("R4 status read value", s, 8'h41);
    dataRead();
    check("R4 two-step clear", statusOut, 8'h01);
    readStatus(s);
    runByte(8'hC3, 1'b1, tx);
    check("R9 rx second byte", rxData, 8'hC3);
    dataWrite(8'h00);
    check("R4 read with flag low does not arm", statusOut, 8'h41);
    fullClear();
    check("R4 cleared again", statusOut, 8'h01);
  endtask

  task automatic t_startGate();
    logic [7:0] tx;
    logic seen;
    masterMode = 1; clkPol = 0;
    tryStart("R10 start accepted", 1'b1);
    masterMode = 0;
    tryStart("R10 slave mode blocks", 1'b0);
    masterMode = 1; clkPol = 1;
    tryStart("R10 line not idle blocks", 1'b0);
    clkPol = 0;
    bitCycle(1'b0, seen);
    tryStart("R10 byte in progress blocks", 1'b0);
    for (int i = 6; i >= 0; i--) bitCycle(1'b0, seen);
    check("R10 byte done", statusOut, 8'h41);
    tryStart("R10 done flag blocks", 1'b0);
    fullClear();
    masterMode = 0;
    tx = 0;
  endtask

  task automatic t_collision();
    logic [7:0] tx;
    logic [7:0] rx = 8'h96;
    dataWrite(8'h00);
    @(negedge clk) sdi = rx[7]; tx[7] = sdo;
    sckEdge(1);
    dataWrite(8'hFF);
    check("R6 no collision before first fall", statusOut, 8'h01);
    sckEdge(0);
    dataWrite(8'h00);
    check("R6 collision after first fall", statusOut, 8'h81);
    for (int i = 6; i >= 0; i--) begin
      if (i == 0) auxPin = 0;
      bitCycle(rx[i], tx[i]);
    end
    check("R6 colliding write dropped", tx, 8'h7F);
    check("R6 status after byte", statusOut, 8'hC0);
    check("R9 rx after collision", rxData, 8'h96);
  endtask

  task automatic t_reclear();
    logic [7:0] s, tx;
    logic seen;
    readStatus(s);
    check("R2 both flags", s, 8'hC0);
    bitCycle(1'b1, seen);
    dataRead();
    check("R7 collision set again on late clear", statusOut, 8'h80);
    for (int i = 6; i >= 0; i--) begin
      if (i == 0) auxPin = 1;
      bitCycle(1'b0, tx[i]);
    end
    check("R5 done set again at byte end", statusOut, 8'hC1);
    readStatus(s);
    dataWrite(8'h5A);
    check("R4 clean clear by write", statusOut, 8'h01);
    runByte(8'h0F, 1'b1, tx);
    check("R9 written value transmitted", tx, 8'h5A);
    fullClear();
  endtask

  task automatic t_pinModes();
    logic [7:0] tx;
    logic seen;
    masterMode = 1; clkPol = 1;
    auxPin = 1;
    for (int i = 7; i >= 1; i--) bitCycle(1'b0, seen);
    check("R8 pin unchanged mid-byte", statusOut, 8'h01);
    auxPin = 0;
    bitCycle(1'b0, seen);
    check("R8 pin sampled at 8th rise", statusOut, 8'h40);
    auxPin = 1;
    repeat (3) @(negedge clk);
    check("R8 pin held", statusOut, 8'h40);
    masterMode = 0; clkPol = 0;
    fullClear();
    check("R8 cleared keeps pin", statusOut, 8'h00);
    tx = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    t_reset();
    t_basicByte();
    t_clearSeq();
    t_startGate();
    t_collision();
    t_reclear();
    t_pinModes();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end
endmodule